// File: doc/BRIEF.md
# Store Queue Forwarding Candidate Masks

This block tells a load which store queue entries may supply its data through store-to-load forwarding. It keeps one physical address per store queue entry with an address-valid bit, compares the load's address against all of them at once, and keeps only the matches that lie in the age window between the oldest store (the dequeue pointer) and the load's own position in the store queue. Both pointers are an entry index plus a wrap flag that toggles each time the pointer passes the last entry.

When the window wraps past the last entry, it is reported as two vectors. The lower vector covers the part from the dequeue index upward. The upper vector covers the part from entry 0 up to the load's index. A downstream byte selector ranks the upper vector above the lower one, and higher indices above lower ones within each vector. That gives it the youngest older store without any pointer arithmetic. Both vectors are registered once, so they line up with the data read that the same load starts in that cycle. A read port with a registered index returns one entry's address and valid bit.

The entry count must be a power of two. The pointers must describe a legal queue, which means at most ENTRIES stores lie between the dequeue pointer and the load's position.

Top module: `sq_fwd_cand`

## Requirements
- R1: While rst_n is low at a clock edge, that edge clears every entry's address to zero and clears every valid bit. The edge also forces cand_lo and cand_hi to all zeros.
- R2: rd_idx is sampled at a clock edge. During the following cycle, rd_addr and rd_vld show that entry's contents, including any write made at that same edge.
- R3: When deq_flag equals ld_flag, bit e of cand_lo is set only if deq_idx <= e < ld_idx and entry e is a hit. In this case cand_hi is all zeros.
- R4: When deq_flag differs from ld_flag, bit e of cand_lo equals (e >= deq_idx and entry e is a hit). Bit e of cand_hi equals (e < ld_idx and entry e is a hit).
- R5: An entry is a hit when its valid bit is set and its stored address equals ld_paddr in bits PADDR_W-1 down to 3. Bits 2 to 0 of either address have no effect on the result.
- R6: A write with wr_vld at 1 sets the entry's valid bit, and a write with wr_vld at 0 clears it. An entry whose valid bit is clear never appears in either output.
- R7: The candidate outputs are registered. After a clock edge they reflect the pointer inputs, ld_paddr and the array contents as they stood before that edge. An address written at an edge first affects the outputs one edge later.
- R8: Equal indices with equal flags give two all-zero vectors. Equal indices with different flags (a full queue) give cand_lo = hits at e >= deq_idx and cand_hi = hits at e < deq_idx.
- R9: Several write ports active in the same cycle at distinct entries all take effect at that edge. Two ports aimed at the same entry in one cycle is an illegal input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NWR | Per-port write enable |
| wr_idx | input | NWR x IDXW | Per-port entry index |
| wr_addr | input | NWR x PADDR_W | Per-port physical address to store |
| wr_vld | input | NWR | Per-port value for the entry's valid bit |
| rd_idx | input | IDXW | Read port entry index (registered) |
| rd_addr | output | PADDR_W | Address of the entry selected last edge |
| rd_vld | output | 1 | Valid bit of the entry selected last edge |
| deq_idx | input | IDXW | Dequeue pointer index (oldest store) |
| deq_flag | input | 1 | Dequeue pointer wrap flag |
| ld_idx | input | IDXW | Load's store queue index |
| ld_flag | input | 1 | Load's store queue wrap flag |
| ld_paddr | input | PADDR_W | Load physical address |
| cand_lo | output | ENTRIES | Registered candidates in the older (or only) region |
| cand_hi | output | ENTRIES | Registered candidates in the wrapped, younger region |

## Verification
The assertions assume two things about the inputs: no two write ports target one entry in the same cycle, and the pointer pair never describes more than ENTRIES stores in flight. The second assumption is what keeps the two vectors disjoint. The stimulus draws the second write index as a nonzero random offset from the first. It places the load pointer at a random occupancy from 0 to ENTRIES past the dequeue pointer, carrying into the wrap flag. Load addresses are usually copies of stored addresses with random low bits, so that hits, misses and cleared entries all occur often.

// File: rtl/sqfc_pkg.sv
// Package: constants shared by the forwarding candidate block.
// Assumes forwarding works on 8-byte words, so the lowest 3 address bits
// never take part in matching.
package sqfc_pkg;
    localparam int unsigned WORD_LSB = 3;
endpackage

// File: rtl/sqfc_addr_array.sv
// Module: sqfc_addr_array
// Holds one physical address and one valid bit per store queue entry.
// It has NWR write ports, one read port with a registered index, and a
// parallel word-granular compare of every entry against the load address.
// Assumes no two write ports address the same entry in one cycle. If they
// do, the higher-numbered port wins.
module sqfc_addr_array #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PADDR_W = 36,
    parameter int unsigned NWR     = 2,
    parameter int unsigned LSB_IGN = 3,
    localparam int unsigned IDXW   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NWR-1:0]                  wr_en,
    input  logic [NWR-1:0][IDXW-1:0]        wr_idx,
    input  logic [NWR-1:0][PADDR_W-1:0]     wr_addr,
    input  logic [NWR-1:0]                  wr_vld,
    input  logic [IDXW-1:0]                 rd_idx,
    output logic [PADDR_W-1:0]              rd_addr,
    output logic                            rd_vld,
    input  logic [PADDR_W-1:0]              ld_paddr,
    output logic [ENTRIES-1:0]              hit_vec,
    output logic [ENTRIES-1:0]              vld_vec
);
    logic [PADDR_W-1:0] addr_mem [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [IDXW-1:0]    rd_ptr_q;

    // Address storage: cleared on reset, then written by each enabled port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) addr_mem[e] <= '0;
        end else begin
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p]) addr_mem[wr_idx[p]] <= wr_addr[p];
            end
        end
    end

    // Valid bits: cleared on reset, set or cleared by each enabled port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p]) vld_q[wr_idx[p]] <= wr_vld[p];
            end
        end
    end

    // Read index register: data follows one cycle after the index.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_ptr_q <= '0;
        else        rd_ptr_q <= rd_idx;
    end

    assign rd_addr = addr_mem[rd_ptr_q];
    assign rd_vld  = vld_q[rd_ptr_q];
    assign vld_vec = vld_q;

    // Per-entry word compare, qualified by the valid bit.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = vld_q[e] &&
            (addr_mem[e][PADDR_W-1:LSB_IGN] == ld_paddr[PADDR_W-1:LSB_IGN]);
    end
endmodule

// File: rtl/sqfc_age_range.sv
// Module: sqfc_age_range
// Builds the two age-window masks from the dequeue pointer and the load's
// store queue pointer. Each mask comes from a thermometer code of one index.
// Assumes ENTRIES is a power of two and that the pointers describe at most
// ENTRIES stores in flight. The load's own index is excluded.
module sqfc_age_range #(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDXW   = $clog2(ENTRIES)
) (
    input  logic [IDXW-1:0]    deq_idx,
    input  logic               deq_flag,
    input  logic [IDXW-1:0]    ld_idx,
    input  logic               ld_flag,
    output logic [ENTRIES-1:0] span_lo,
    output logic [ENTRIES-1:0] span_hi
);
    logic [ENTRIES-1:0] at_or_above_deq;
    logic [ENTRIES-1:0] below_ld;
    logic               same_lap;

    // Thermometer codes of both indices.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_therm
        assign at_or_above_deq[e] = (IDXW'(e) >= deq_idx);
        assign below_ld[e]        = (IDXW'(e) <  ld_idx);
    end

    assign same_lap = (deq_flag == ld_flag);

    // Choose between the contiguous window and the wrapped pair of windows.
    always_comb begin
        if (same_lap) begin
            span_lo = at_or_above_deq & below_ld;
            span_hi = '0;
        end else begin
            span_lo = at_or_above_deq;
            span_hi = below_ld;
        end
    end
endmodule

// File: rtl/sq_fwd_cand.sv
// Module: sq_fwd_cand (top)
// Finds the store queue entries that a load must examine for forwarding.
// The address hits are masked by the age window, and both candidate
// vectors are registered once so they line up with a data read started
// in the same cycle. cand_hi ranks above cand_lo for a downstream selector.
// Assumes distinct write indices per cycle and legal queue pointers.
module sq_fwd_cand #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PADDR_W = 36,
    parameter int unsigned NWR     = 2,
    localparam int unsigned IDXW   = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NWR-1:0]              wr_en,
    input  logic [NWR-1:0][IDXW-1:0]    wr_idx,
    input  logic [NWR-1:0][PADDR_W-1:0] wr_addr,
    input  logic [NWR-1:0]              wr_vld,
    input  logic [IDXW-1:0]             rd_idx,
    output logic [PADDR_W-1:0]          rd_addr,
    output logic                        rd_vld,
    input  logic [IDXW-1:0]             deq_idx,
    input  logic                        deq_flag,
    input  logic [IDXW-1:0]             ld_idx,
    input  logic                        ld_flag,
    input  logic [PADDR_W-1:0]          ld_paddr,
    output logic [ENTRIES-1:0]          cand_lo,
    output logic [ENTRIES-1:0]          cand_hi
);
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] entry_vld;
    logic [ENTRIES-1:0] span_lo;
    logic [ENTRIES-1:0] span_hi;

    sqfc_addr_array #(
        .ENTRIES (ENTRIES),
        .PADDR_W (PADDR_W),
        .NWR     (NWR),
        .LSB_IGN (sqfc_pkg::WORD_LSB)
    ) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_addr  (wr_addr),
        .wr_vld   (wr_vld),
        .rd_idx   (rd_idx),
        .rd_addr  (rd_addr),
        .rd_vld   (rd_vld),
        .ld_paddr (ld_paddr),
        .hit_vec  (hit_vec),
        .vld_vec  (entry_vld)
    );

    sqfc_age_range #(
        .ENTRIES (ENTRIES)
    ) i_range (
        .deq_idx  (deq_idx),
        .deq_flag (deq_flag),
        .ld_idx   (ld_idx),
        .ld_flag  (ld_flag),
        .span_lo  (span_lo),
        .span_hi  (span_hi)
    );

    // Output stage: register the masked candidates for alignment with the data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_lo <= '0;
            cand_hi <= '0;
        end else begin
            cand_lo <= span_lo & hit_vec;
            cand_hi <= span_hi & hit_vec;
        end
    end
endmodule

// File: rtl/sqfc_checker.sv
// Module: sqfc_checker
// Temporal properties for sq_fwd_cand, attached to it through bind.
// Assumes it sees the top's ports and its per-entry valid vector.
module sqfc_checker #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned NWR     = 2,
    localparam int unsigned IDXW   = $clog2(ENTRIES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NWR-1:0]           wr_en,
    input logic [NWR-1:0][IDXW-1:0] wr_idx,
    input logic [IDXW-1:0]          deq_idx,
    input logic                     deq_flag,
    input logic [IDXW-1:0]          ld_idx,
    input logic                     ld_flag,
    input logic [ENTRIES-1:0]       cand_lo,
    input logic [ENTRIES-1:0]       cand_hi,
    input logic [ENTRIES-1:0]       entry_vld
);
    logic               live_q;
    logic               same_q;
    logic               empty_q;
    logic [ENTRIES-1:0] below_deq_q;
    logic [ENTRIES-1:0] vld_prev_q;

    // Capture last cycle's pointer facts, independently of the design.
    always_ff @(posedge clk) begin
        live_q     <= rst_n;
        same_q     <= (deq_flag == ld_flag);
        empty_q    <= (deq_flag == ld_flag) && (deq_idx == ld_idx);
        vld_prev_q <= entry_vld;
        for (int e = 0; e < ENTRIES; e++) below_deq_q[e] <= (e < int'(deq_idx));
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cand_lo == '0 && cand_hi == '0));

    p_same_lap_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && same_q) |-> (cand_hi == '0));

    p_lo_not_below_deq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((cand_lo & below_deq_q) == '0));

    p_cand_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (((cand_lo | cand_hi) & ~vld_prev_q) == '0));

    p_equal_ptr_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && empty_q) |-> (cand_lo == '0 && cand_hi == '0));

    for (genvar a = 0; a < NWR; a++) begin : g_pa
        for (genvar b = a + 1; b < NWR; b++) begin : g_pb
            p_no_wr_conflict_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[a] && wr_en[b]) |-> (wr_idx[a] != wr_idx[b]));
        end
    end
endmodule

bind sq_fwd_cand sqfc_checker #(
    .ENTRIES (ENTRIES),
    .NWR     (NWR)
) i_sqfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .deq_idx   (deq_idx),
    .deq_flag  (deq_flag),
    .ld_idx    (ld_idx),
    .ld_flag   (ld_flag),
    .cand_lo   (cand_lo),
    .cand_hi   (cand_hi),
    .entry_vld (entry_vld)
);

// File: tb/test_sq_fwd_cand.sv
module test_sq_fwd_cand;
    localparam int unsigned ENTRIES = 16;
    localparam int unsigned PADDR_W = 36;
    localparam int unsigned NWR     = 2;
    localparam int unsigned IDXW    = $clog2(ENTRIES);

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [NWR-1:0]              wr_en = '0;
    logic [NWR-1:0][IDXW-1:0]    wr_idx = '0;
    logic [NWR-1:0][PADDR_W-1:0] wr_addr = '0;
    logic [NWR-1:0]              wr_vld = '0;
    logic [IDXW-1:0]             rd_idx = '0;
    logic [PADDR_W-1:0]          rd_addr;
    logic                        rd_vld;
    logic [IDXW-1:0]             deq_idx = '0;
    logic                        deq_flag = 1'b0;
    logic [IDXW-1:0]             ld_idx = '0;
    logic                        ld_flag = 1'b0;
    logic [PADDR_W-1:0]          ld_paddr = '0;
    logic [ENTRIES-1:0]          cand_lo;
    logic [ENTRIES-1:0]          cand_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [PADDR_W-1:0] m_addr [ENTRIES];
    logic               m_vld  [ENTRIES];
    logic [ENTRIES-1:0] exp_lo, exp_hi;

    sq_fwd_cand #(.ENTRIES(ENTRIES), .PADDR_W(PADDR_W), .NWR(NWR)) i_sq_fwd_cand (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_addr(wr_addr), .wr_vld(wr_vld), .rd_idx(rd_idx),
        .rd_addr(rd_addr), .rd_vld(rd_vld), .deq_idx(deq_idx),
        .deq_flag(deq_flag), .ld_idx(ld_idx), .ld_flag(ld_flag),
        .ld_paddr(ld_paddr), .cand_lo(cand_lo), .cand_hi(cand_hi)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected candidates from the requirements and the model before the edge.
    task automatic predict();
        for (int e = 0; e < ENTRIES; e++) begin
            bit ge  = (e >= int'(deq_idx));
            bit lt  = (e <  int'(ld_idx));
            bit hit = m_vld[e] && ((m_addr[e] >> 3) == (ld_paddr >> 3));
            if (deq_flag == ld_flag) begin
                exp_lo[e] = ge && lt && hit;
                exp_hi[e] = 1'b0;
            end else begin
                exp_lo[e] = ge && hit;
                exp_hi[e] = lt && hit;
            end
        end
    endtask

    // One cycle: predict, clock, update the model, then check at the falling edge.
    task automatic step(string req);
        predict();
        @(posedge clk);
        for (int p = 0; p < NWR; p++) begin
            if (wr_en[p]) begin
                m_addr[wr_idx[p]] = wr_addr[p];
                m_vld[wr_idx[p]]  = wr_vld[p];
            end
        end
        @(negedge clk);
        chk(req, "cand_lo", 64'(cand_lo), 64'(exp_lo));
        chk(req, "cand_hi", 64'(cand_hi), 64'(exp_hi));
        chk("R2", "rd_addr", 64'(rd_addr), 64'(m_addr[rd_idx]));
        chk("R2", "rd_vld", 64'(rd_vld), 64'(m_vld[rd_idx]));
    endtask

    task automatic set_ptrs(int dq, bit dqf, int occ);
        logic [IDXW:0] lp;
        lp = {dqf, IDXW'(dq)} + (IDXW+1)'(occ);
        deq_idx = IDXW'(dq); deq_flag = dqf;
        ld_idx = lp[IDXW-1:0]; ld_flag = lp[IDXW];
    endtask

    task automatic idle_wr();
        wr_en = '0;
    endtask

    initial begin
        for (int e = 0; e < ENTRIES; e++) begin m_addr[e] = '0; m_vld[e] = 1'b0; end
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        chk("R1", "cand_lo", 64'(cand_lo), 64'd0);
        chk("R1", "cand_hi", 64'(cand_hi), 64'd0);
        chk("R1", "rd_vld", 64'(rd_vld), 64'd0);
        chk("R1", "rd_addr", 64'(rd_addr), 64'd0);
        rst_n = 1'b1;

        // R9: two ports write distinct entries in one cycle.
        wr_en = 2'b11; wr_idx[0] = 4'd3; wr_idx[1] = 4'd9;
        wr_addr[0] = 36'h0_1234_5670; wr_addr[1] = 36'h0_0ABC_DE08; wr_vld = 2'b11;
        // R7: load matches entry 3's new address at the same edge; no hit yet.
        set_ptrs(0, 1'b0, ENTRIES-1); ld_paddr = 36'h0_1234_5670; rd_idx = 4'd3;
        step("R7");
        idle_wr(); rd_idx = 4'd9;
        step("R7 R9");
        chk("R7", "cand_lo bit3 next cycle", 64'(cand_lo[3]), 64'd1);

        // R5: low bits ignored, bit 3 is significant.
        ld_paddr = 36'h0_1234_5677;
        step("R5");
        chk("R5", "low bits ignored", 64'(cand_lo[3]), 64'd1);
        ld_paddr = 36'h0_1234_5678;
        step("R5");
        chk("R5", "bit3 differs", 64'(cand_lo[3]), 64'd0);

        // R6: clear entry 3's valid bit, same address then misses.
        wr_en = 2'b01; wr_idx[0] = 4'd3; wr_vld = 2'b00; wr_addr[0] = 36'h0_1234_5670;
        ld_paddr = 36'h0_1234_5670;
        step("R6");
        idle_wr();
        step("R6");
        chk("R6", "cleared entry", 64'(cand_lo | cand_hi), 64'd0);

        // Fill all entries with the same word so window shapes are visible.
        for (int e = 0; e < ENTRIES; e += 2) begin
            wr_en = 2'b11; wr_idx[0] = IDXW'(e); wr_idx[1] = IDXW'(e+1);
            wr_addr[0] = 36'h0_7777_0000; wr_addr[1] = 36'h0_7777_0004; wr_vld = 2'b11;
            step("R9");
        end
        idle_wr(); ld_paddr = 36'h0_7777_0002;
        // R8: equal pointers, same flag: empty.
        set_ptrs(5, 1'b1, 0);
        step("R8");
        chk("R8", "empty lo", 64'(cand_lo), 64'd0);
        // R8: equal indices, different flags: full queue.
        set_ptrs(5, 1'b0, ENTRIES);
        step("R8");
        chk("R8", "full lo", 64'(cand_lo), 64'hFFE0);
        chk("R8", "full hi", 64'(cand_hi), 64'h001F);
        // R3: same lap window 4..9.
        set_ptrs(4, 1'b0, 6);
        step("R3");
        chk("R3", "window lo", 64'(cand_lo), 64'h03F0);
        // R4: wrapped, deq 12, load index 2.
        set_ptrs(12, 1'b1, 6);
        step("R4");
        chk("R4", "wrapped lo", 64'(cand_lo), 64'hF000);
        chk("R4", "wrapped hi", 64'(cand_hi), 64'h0003);

        // Constrained random phase.
        for (int n = 0; n < 3000; n++) begin
            int occ;
            int w0;
            for (int p = 0; p < NWR; p++) begin
                wr_en[p]   = ($urandom_range(0, 2) != 0);
                wr_vld[p]  = ($urandom_range(0, 4) != 0);
                wr_addr[p] = {4'h0, 16'h5A00 | 16'($urandom_range(0, 7)), 16'($urandom)};
            end
            w0 = $urandom_range(0, ENTRIES-1);
            wr_idx[0] = IDXW'(w0);
            wr_idx[1] = IDXW'(w0 + $urandom_range(1, ENTRIES-1));
            occ = $urandom_range(0, ENTRIES);
            set_ptrs($urandom_range(0, ENTRIES-1), 1'($urandom_range(0, 1)), occ);
            if ($urandom_range(0, 9) < 7)
                ld_paddr = m_addr[$urandom_range(0, ENTRIES-1)] ^ PADDR_W'($urandom_range(0, 7));
            else
                ld_paddr = {4'h0, 32'($urandom)};
            rd_idx = IDXW'($urandom_range(0, ENTRIES-1));
            if (occ == 0 || occ == ENTRIES) step("R8 R5 R6");
            else if (deq_flag == ld_flag) step("R3 R5 R6 R7");
            else step("R4 R5 R6 R7");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule